// File: doc/BRIEF.md
# General-Purpose Event Bank

This block holds a parameterised set of general-purpose event flags behind a byte-wide register port. The register space is `BANK_LEN` bytes long, cut into two equal halves. The lower half holds status bytes and the upper half holds the matching enable bytes. Hardware event sources set status bits. Software acknowledges a flag by writing a one to it, and arms or disarms sources by writing whole enable bytes.

The block also drives a single level-sensitive system interrupt. The interrupt is raised when the first status byte has any bit that is also set in the first enable byte. It is also raised when the power-management event status word from a neighbouring register block, taken together with that block's enable word and limited to a fixed set of common event bits, has any bit left over. Status bytes other than the first are visible only through reads.

Top module: `gpe_bank`

## Requirements
- R1: While `rst_n` is low, all status and enable bytes are zero, `irq` is low, `reg_err` is low and `reg_rdata` is zero. After release they stay zero until written or set by an event.
- R2: With `H = BANK_LEN/2`, the access address `a` selects status byte `a` when `a < H`. It selects enable byte `a-H` when `H <= a < BANK_LEN`.
- R3: A write to a status byte clears each bit whose write-data bit is one. Bits written as zero keep their value, and a write never sets a status bit.
- R4: A write to an enable byte replaces the whole byte with the write data.
- R5: Bit `8*i+b` of `hw_event` ORs into bit `b` of status byte `i` at the next clock edge. Event bits that are zero have no effect.
- R6: When an event bit and a clearing write to the same status bit fall in the same cycle, the bit ends up set.
- R7: `irq` is high when status byte 0 AND enable byte 0 has any bit set.
- R8: `irq` is also high when `pm_sts AND pm_en AND PM_COMMON_MASK` is nonzero. The default mask keeps bits 0, 8 and 10, so matching bits at other positions do not raise `irq`.
- R9: An access with address `>= BANK_LEN` changes no byte on a write and returns zero on a read. It pulses `reg_err` high for exactly the cycle after that access.
- R10: A read (`reg_cs=1`, `reg_we=0`) presents the selected byte on `reg_rdata` one cycle later. `reg_rdata` holds its value in cycles without a read.
- R11: Status and enable bytes other than byte 0 do not affect `irq`.
- R12: `irq` takes its new level in the cycle after the write, event or input change that caused it. This covers both rising and falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW ($clog2(BANK_LEN)+1) | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the read |
| reg_err | output | 1 | One-cycle pulse after an out-of-range access |
| hw_event | input | 8*BANK_LEN/2 | Event set bits, one byte per status byte |
| pm_sts | input | PM_W | Event status word from the power-management block |
| pm_en | input | PM_W | Event enable word from the power-management block |
| irq | output | 1 | Level-sensitive system interrupt |

## Verification
A corrupted status or enable byte 0 shows on `irq` within one cycle, as soon as a set bit is present in both bytes. A corrupted higher byte stays hidden until a read of that address, and the read returns it one cycle later. A decode fault, such as an out-of-range write that wraps onto a real byte, appears only at the next read of the byte it hit. For that reason the vector table writes to an address that would alias an enable byte and then reads that enable byte back. A mistake in the event-versus-clear priority leaves a status bit at the wrong value, and the bench catches it by reading the byte straight after a combined write-and-event cycle.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  // Target class of one register access
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_BAD  = 2'd3
  } sel_e;

  // Write-one-to-clear merged with incoming set bits; set bits dominate
  function automatic logic [7:0] w1c_merge(input logic [7:0] cur,
                                           input logic [7:0] clr,
                                           input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/gpe_addr_dec.sv
module gpe_addr_dec
  import gpe_pkg::*;
#(
  parameter int BANK_LEN = 4,
  parameter int HALF     = BANK_LEN / 2,
  parameter int AW       = $clog2(BANK_LEN) + 1,
  parameter int IW       = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic            cs,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  output logic [HALF-1:0] sts_wr,
  output logic [HALF-1:0] en_wr,
  output sel_e            sel,
  output logic [IW-1:0]   idx
);

  // Per-byte write strobes
  genvar g;
  generate
    for (g = 0; g < HALF; g++) begin : g_strobe
      assign sts_wr[g] = cs && we && (addr == AW'(g));
      assign en_wr[g]  = cs && we && (addr == AW'(HALF + g));
    end
  endgenerate

  // Target class and byte index for the read path and error flag
  always_comb begin
    sel = cs ? SEL_BAD : SEL_NONE;
    idx = '0;
    if (cs) begin
      for (int i = 0; i < HALF; i++) begin
        if (addr == AW'(i)) begin
          sel = SEL_STS;
          idx = IW'(i);
        end
        if (addr == AW'(HALF + i)) begin
          sel = SEL_EN;
          idx = IW'(i);
        end
      end
    end
  end

endmodule

// File: rtl/gpe_sts_byte.sv
module gpe_sts_byte
  import gpe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_en,
  input  logic [7:0] clr_mask,
  input  logic [7:0] set_mask,
  output logic [7:0] d,
  output logic [7:0] q
);

  logic upd;

  always_comb begin
    upd = clr_en || (set_mask != 8'h00);
    if (clr_en) d = w1c_merge(q, clr_mask, set_mask);
    else        d = q | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 8'h00;
    else if (upd) q <= d;
  end

endmodule

// File: rtl/gpe_en_byte.sv
module gpe_en_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] d,
  output logic [7:0] q
);

  always_comb begin
    d = wr_en ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 8'h00;
    else if (wr_en) q <= d;
  end

endmodule

// File: rtl/gpe_irq_comb.sv
module gpe_irq_comb #(
  parameter int              PM_W           = 16,
  parameter logic [PM_W-1:0] PM_COMMON_MASK = 'h0501
) (
  input  logic [7:0]      sts0,
  input  logic [7:0]      en0,
  input  logic [PM_W-1:0] pm_sts,
  input  logic [PM_W-1:0] pm_en,
  output logic            level
);

  logic gp_hit;
  logic pm_hit;

  always_comb begin
    gp_hit = |(sts0 & en0);
    pm_hit = |(pm_sts & pm_en & PM_COMMON_MASK);
    level  = gp_hit || pm_hit;
  end

endmodule

// File: rtl/gpe_bank.sv
module gpe_bank
  import gpe_pkg::*;
#(
  parameter int              BANK_LEN       = 4,
  parameter int              PM_W           = 16,
  parameter logic [PM_W-1:0] PM_COMMON_MASK = 'h0501,
  localparam int             HALF           = BANK_LEN / 2,
  localparam int             AW             = $clog2(BANK_LEN) + 1,
  localparam int             IW             = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int             EVW            = HALF * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_cs,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            reg_err,
  input  logic [EVW-1:0]  hw_event,
  input  logic [PM_W-1:0] pm_sts,
  input  logic [PM_W-1:0] pm_en,
  output logic            irq
);

  logic [HALF-1:0] sts_wr;
  logic [HALF-1:0] en_wr;
  sel_e            sel;
  logic [IW-1:0]   idx;

  logic [7:0] sts_d [HALF];
  logic [7:0] sts_q [HALF];
  logic [7:0] en_d  [HALF];
  logic [7:0] en_q  [HALF];

  // Flat views of the byte state, used by the bound checker
  logic [EVW-1:0] sts_flat;
  logic [EVW-1:0] en_flat;

  gpe_addr_dec #(
    .BANK_LEN (BANK_LEN),
    .HALF     (HALF),
    .AW       (AW),
    .IW       (IW)
  ) u_dec (
    .cs     (reg_cs),
    .we     (reg_we),
    .addr   (reg_addr),
    .sts_wr (sts_wr),
    .en_wr  (en_wr),
    .sel    (sel),
    .idx    (idx)
  );

  genvar g;
  generate
    for (g = 0; g < HALF; g++) begin : g_byte
      gpe_sts_byte u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (sts_wr[g]),
        .clr_mask (reg_wdata),
        .set_mask (hw_event[g*8 +: 8]),
        .d        (sts_d[g]),
        .q        (sts_q[g])
      );
      gpe_en_byte u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (en_wr[g]),
        .wdata (reg_wdata),
        .d     (en_d[g]),
        .q     (en_q[g])
      );
      assign sts_flat[g*8 +: 8] = sts_q[g];
      assign en_flat[g*8 +: 8]  = en_q[g];
    end
  endgenerate

  // Interrupt level from next-state byte 0 so it lands with the update
  logic irq_d;

  gpe_irq_comb #(
    .PM_W           (PM_W),
    .PM_COMMON_MASK (PM_COMMON_MASK)
  ) u_irq (
    .sts0   (sts_d[0]),
    .en0    (en_d[0]),
    .pm_sts (pm_sts),
    .pm_en  (pm_en),
    .level  (irq_d)
  );

  // Read path and error flag, next state
  logic       rd_en;
  logic [7:0] rd_byte;
  logic [7:0] rdata_d;
  logic       err_d;

  always_comb begin
    rd_en = reg_cs && !reg_we;
    case (sel)
      SEL_STS: rd_byte = sts_q[idx];
      SEL_EN:  rd_byte = en_q[idx];
      default: rd_byte = 8'h00;
    endcase
    rdata_d = rd_en ? rd_byte : reg_rdata;
    err_d   = (sel == SEL_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= 8'h00;
      reg_err   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (rd_en) reg_rdata <= rdata_d;
      reg_err <= err_d;
      irq     <= irq_d;
    end
  end

endmodule

// File: rtl/gpe_bank_chk.sv
module gpe_bank_chk #(
  parameter int              BANK_LEN       = 4,
  parameter int              PM_W           = 16,
  parameter logic [PM_W-1:0] PM_COMMON_MASK = 'h0501,
  parameter int              HALF           = BANK_LEN / 2,
  parameter int              AW             = $clog2(BANK_LEN) + 1,
  parameter int              EVW            = HALF * 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_cs,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic [7:0]      reg_wdata,
  input logic            reg_err,
  input logic [EVW-1:0]  hw_event,
  input logic [PM_W-1:0] pm_sts,
  input logic [PM_W-1:0] pm_en,
  input logic            irq,
  input logic [EVW-1:0]  sts_flat,
  input logic [EVW-1:0]  en_flat
);

  logic bad_acc;
  assign bad_acc = reg_cs && (reg_addr >= AW'(BANK_LEN));

  // R5 R6
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != '0) |=> ((sts_flat & $past(hw_event)) == $past(hw_event)));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(bad_acc));

  // R9
  bad_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_acc && reg_we && hw_event == '0) |=> ($stable(sts_flat) && $stable(en_flat)));

  // R7 R8 R11 R12
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == (((sts_flat[7:0] & en_flat[7:0]) != 8'h00) ||
                              (($past(pm_sts) & $past(pm_en) & PM_COMMON_MASK) != '0))));

  genvar j;
  generate
    for (j = 0; j < HALF; j++) begin : g_byte_chk
      // R4
      en_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cs && reg_we && reg_addr == AW'(HALF + j)) |=> (en_flat[j*8 +: 8] == $past(reg_wdata)));

      // R3
      sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cs && reg_we && reg_addr == AW'(j) && hw_event[j*8 +: 8] == 8'h00)
        |=> ((sts_flat[j*8 +: 8] & $past(reg_wdata)) == 8'h00));
    end
  endgenerate

endmodule

bind gpe_bank gpe_bank_chk #(
  .BANK_LEN       (BANK_LEN),
  .PM_W           (PM_W),
  .PM_COMMON_MASK (PM_COMMON_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_cs    (reg_cs),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_err   (reg_err),
  .hw_event  (hw_event),
  .pm_sts    (pm_sts),
  .pm_en     (pm_en),
  .irq       (irq),
  .sts_flat  (sts_flat),
  .en_flat   (en_flat)
);

// File: tb/gpe_bank_tb.sv
module gpe_bank_tb;

  localparam int BANK_LEN = 4;
  localparam int AW       = $clog2(BANK_LEN) + 1;
  localparam int EVW      = (BANK_LEN / 2) * 8;
  localparam int NV       = 21;
  localparam int VW       = 77;

  // {op(2: 0 idle,1 read,2 write), addr(8), wdata(8), event(16),
  //  pm_sts(16), pm_en(16), exp_rdata(8), exp_irq, exp_err, chk_rdata}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd1, 8'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1}, // R1 R2
    {2'd2, 8'd2, 8'h0F, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {2'd0, 8'd0, 8'h00, 16'h0030, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R5 R7
    {2'd1, 8'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h30, 1'b0, 1'b0, 1'b1}, // R5 R2
    {2'd0, 8'd0, 8'h00, 16'h0001, 16'h0000, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0}, // R7 R12
    {2'd2, 8'd0, 8'h01, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R3 R12
    {2'd1, 8'd2, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h0F, 1'b0, 1'b0, 1'b1}, // R4 R2
    {2'd2, 8'd3, 8'hFF, 16'h8000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R11 R5
    {2'd1, 8'd1, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h80, 1'b0, 1'b0, 1'b1}, // R2 R5
    {2'd0, 8'd0, 8'h00, 16'h0000, 16'h0002, 16'h0002, 8'h00, 1'b0, 1'b0, 1'b0}, // R8 unmasked bit
    {2'd0, 8'd0, 8'h00, 16'h0000, 16'h0100, 16'h0100, 8'h00, 1'b1, 1'b0, 1'b0}, // R8 bit 8
    {2'd0, 8'd0, 8'h00, 16'h0000, 16'h0400, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R8 not enabled
    {2'd2, 8'd7, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0}, // R9 write
    {2'd1, 8'd3, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hFF, 1'b0, 1'b0, 1'b1}, // R9 no alias
    {2'd1, 8'd6, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b1}, // R9 read
    {2'd2, 8'd0, 8'h30, 16'h0010, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R6
    {2'd1, 8'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h10, 1'b0, 1'b0, 1'b1}, // R6 R3
    {2'd0, 8'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h10, 1'b0, 1'b0, 1'b1}, // R10 hold
    {2'd0, 8'd0, 8'h00, 16'h0000, 16'h0401, 16'h0400, 8'h00, 1'b1, 1'b0, 1'b0}, // R8 bit 10
    {2'd0, 8'd0, 8'h00, 16'h0000, 16'h0001, 16'h0001, 8'h00, 1'b1, 1'b0, 1'b0}, // R8 bit 0
    {2'd0, 8'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0}  // R12 fall
  };

  logic            clk;
  logic            rst_n;
  logic            reg_cs;
  logic            reg_we;
  logic [AW-1:0]   reg_addr;
  logic [7:0]      reg_wdata;
  logic [7:0]      reg_rdata;
  logic            reg_err;
  logic [EVW-1:0]  hw_event;
  logic [15:0]     pm_sts;
  logic [15:0]     pm_en;
  logic            irq;

  int checks;
  int fails;
  bit done;

  gpe_bank #(.BANK_LEN(BANK_LEN)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_cs    (reg_cs),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_err   (reg_err),
    .hw_event  (hw_event),
    .pm_sts    (pm_sts),
    .pm_en     (pm_en),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [7:0] a, input logic [7:0] wd,
                       input logic [15:0] ev, input logic [15:0] ps, input logic [15:0] pe);
    reg_cs    = (op != 2'd0);
    reg_we    = (op == 2'd2);
    reg_addr  = a[AW-1:0];
    reg_wdata = wd;
    hw_event  = ev;
    pm_sts    = ps;
    pm_en     = pe;
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    drive(2'd0, 8'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 err after reset", {7'd0, reg_err}, 8'h00);
    check("R1 rdata after reset", reg_rdata, 8'h00);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      drive(v[76:75], v[74:67], v[66:59], v[58:43], v[42:27], v[26:11]);
      @(negedge clk);
      check($sformatf("R7/R8/R11/R12 irq row %0d", k), {7'd0, irq}, {7'd0, v[2]});
      check($sformatf("R9 err row %0d", k), {7'd0, reg_err}, {7'd0, v[1]});
      if (v[0]) check($sformatf("R2/R10 rdata row %0d", k), reg_rdata, v[10:3]);
    end

    // Directed: reset in the middle of activity (R1)
    drive(2'd0, 8'd0, 8'h00, 16'h0001, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R7 irq before reset", {7'd0, irq}, 8'h01);
    drive(2'd0, 8'd0, 8'h00, 16'h0000, 16'h0001, 16'h0001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq held low in reset", {7'd0, irq}, 8'h00);
    check("R1 rdata cleared by reset", reg_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 R12 irq after release", {7'd0, irq}, 8'h01);
    drive(2'd1, 8'd3, 8'h00, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R1 enable byte cleared", reg_rdata, 8'h00);
    check("R12 irq drops", {7'd0, irq}, 8'h00);
    drive(2'd1, 8'd1, 8'h00, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R1 status byte cleared", reg_rdata, 8'h00);

    // Directed: writing ones to a clear status bit does not set it (R3)
    drive(2'd2, 8'd1, 8'hFF, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);
    drive(2'd1, 8'd1, 8'h00, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R3 write does not set status", reg_rdata, 8'h00);
    drive(2'd0, 8'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule